// File: doc/BRIEF.md
# External Bus Write Cycle Controller

This block is the bus-master sequencer that carries one internal write request out to an external 32-bit data bus made of two 16-bit lanes. The request gives the address, the data, a transfer size (byte, halfword or word) and a 3-bit access-type code. Once accepted, the block steps through an address phase, zero or more wait phases and a data phase. Each phase is one clock long. It drives the address, the size and type codes, a chip select, an output enable that it holds negated, a read/write line and four per-byte enables.

The address phase ends on either of two acknowledge sources: an external transfer-acknowledge input, or an acknowledge from the internal chip-select logic. Without an acknowledge, whole-clock wait phases follow until one arrives or a fixed timeout runs out. Write data appears on the lanes from the first wait phase, or in the data phase when there are no waits. The byte enables drop for the data phase, while the address and control lines stay valid through it. A one-cycle done pulse follows the data phase. A misaligned request, or one with an unknown size, is refused with a one-cycle error pulse, and so is a timed-out transfer.

Top module: `ext_wr_cycle`

## Requirements
- R1: Out of reset and whenever no transfer is running, cs_act, oe_act, be, dout_oe, done and err are all low, rw is high and busy is low.
- R2: An aligned request seen at a clock edge while idle starts the address phase in the next cycle. That phase shows bus_addr, bus_size (00 word, 01 byte, 10 halfword) and bus_kind equal to the request, with cs_act high, oe_act low, rw low, be asserted and dout_oe zero.
- R3: Byte enables are big-endian, with be[3] for bits 31:24 and be[0] for bits 7:0. A byte at address offset n sets only be[3-n]. A halfword at offset 0 sets be[3:2], and one at offset 2 sets be[1:0]. A word sets all four.
- R4: If ack_ext or ack_cs is high during the address phase, the data phase follows in the very next cycle with no wait phases.
- R5: Without an acknowledge, whole-clock wait phases are inserted, with be and all address and control lines held. An acknowledge from either source during a wait phase makes the next cycle the data phase.
- R6: Write data is driven from the first wait phase, or from the data phase when there is none. dout_oe[1] (bits 31:16) is high iff be[3] or be[2] is set, and dout_oe[0] (bits 15:0) iff be[1] or be[0] is set. A byte is copied into all four byte positions and a halfword into both halves.
- R7: The data phase lasts one clock. In it be is zero, while bus_addr, bus_size, bus_kind, cs_act, rw low and the driven data stay as in the earlier phases.
- R8: done is high for exactly one cycle, the cycle after the data phase, and the block is then idle with cs_act low and both lanes released.
- R9: A request with a halfword at an odd offset, a word at a nonzero offset, or size code 11 is not started. err is high for one cycle in the next cycle, and cs_act and done stay low.
- R10: If no acknowledge arrives in TMO_WAITS consecutive wait phases, the transfer is aborted. In the following cycle err pulses for one cycle, cs_act is low, and done stays low. An acknowledge in the last allowed wait still completes normally.
- R11: A request presented while a transfer is running is ignored: bus_addr does not change and no new transfer follows once the request is withdrawn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Write request present |
| req_addr | input | AW | Request byte address |
| req_size | input | 2 | Size code: 00 word, 01 byte, 10 halfword |
| req_kind | input | 3 | Access-type code carried to the bus |
| req_data | input | 32 | Write data, right-justified |
| ack_ext | input | 1 | External transfer acknowledge |
| ack_cs | input | 1 | Internal chip-select acknowledge |
| busy | output | 1 | Transfer in progress |
| bus_addr | output | AW | External address |
| bus_size | output | 2 | External size code |
| bus_kind | output | 3 | External access-type code |
| cs_act | output | 1 | Chip select, active high |
| oe_act | output | 1 | Output enable, active high, held negated |
| rw | output | 1 | High for read/idle, low for write |
| be | output | 4 | Byte enables, be[3] for bits 31:24 |
| dout | output | 32 | Write data lanes |
| dout_oe | output | 2 | Lane drive enables, [1] upper, [0] lower |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle refusal or timeout pulse |

## Verification
The hardest case to reach from the ports is the timeout boundary. An acknowledge in the last permitted wait phase must still complete, while one more empty wait must abort. The bench builds the block with a small wait limit and holds both acknowledges low for exactly that many waits in one run and one fewer in another. It controls the acknowledge inputs cycle by cycle from the bench's half-cycle point, so the number of waits in each run is exact. The zero-wait path is reached by raising an acknowledge during the address phase itself.

// File: rtl/ewc_pkg.sv
package ewc_pkg;

    localparam int DATA_W = 32;
    localparam int LANE_W = 16;
    localparam int LANES  = DATA_W / LANE_W;
    localparam int BYTES  = DATA_W / 8;
    localparam int BPL    = LANE_W / 8;

    typedef enum logic [1:0] {
        SZ_WORD = 2'b00,
        SZ_BYTE = 2'b01,
        SZ_HALF = 2'b10,
        SZ_BAD  = 2'b11
    } xfer_size_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ADDR,
        PH_WAIT,
        PH_DATA
    } phase_e;

    typedef struct packed {
        xfer_size_e          size;
        logic [2:0]          kind;
        logic [1:0]          alo;
        logic [DATA_W-1:0]   data;
    } wreq_t;

    function automatic logic size_ok(xfer_size_e s, logic [1:0] a);
        case (s)
            SZ_BYTE: return 1'b1;
            SZ_HALF: return (a[0] == 1'b0);
            SZ_WORD: return (a == 2'b00);
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [BYTES-1:0] be_of(xfer_size_e s, logic [1:0] a);
        logic [BYTES-1:0] one;
        one = '0;
        one[0] = 1'b1;
        case (s)
            SZ_BYTE: return one << (BYTES - 1 - int'(a));
            SZ_HALF: return (one | (one << 1)) << (BYTES - 2 - int'(a));
            SZ_WORD: return '1;
            default: return '0;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] spread(xfer_size_e s, logic [DATA_W-1:0] d);
        logic [DATA_W-1:0] r;
        r = d;
        for (int i = 0; i < BYTES; i++) begin
            if (s == SZ_BYTE) r[i*8 +: 8] = d[7:0];
        end
        for (int i = 0; i < BYTES / 2; i++) begin
            if (s == SZ_HALF) r[i*16 +: 16] = d[15:0];
        end
        return r;
    endfunction

endpackage

// File: rtl/ewc_lane_map.sv
module ewc_lane_map
    import ewc_pkg::*;
(
    input  wreq_t                    req,
    output logic [BYTES-1:0]         be_map,
    output logic [LANES-1:0]         lane_use,
    output logic [DATA_W-1:0]        lane_data
);

    assign be_map    = be_of(req.size, req.alo);
    assign lane_data = spread(req.size, req.data);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_use[g] = |be_map[g*BPL +: BPL];
    end

endmodule

// File: rtl/ewc_seq.sv
module ewc_seq
    import ewc_pkg::*;
#(
    parameter int TMO_WAITS = 16
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   reject,
    input  logic   ack,
    output phase_e phase,
    output logic   done,
    output logic   err
);

    localparam int CW = $clog2(TMO_WAITS + 1);
    localparam logic [CW-1:0] LAST = CW'(TMO_WAITS - 1);

    phase_e        nxt;
    logic [CW-1:0] wcnt;
    logic          timeout;

    assign timeout = (phase == PH_WAIT) && !ack && (wcnt == LAST);

    always_comb begin
        nxt = phase;
        case (phase)
            PH_IDLE: if (start) nxt = PH_ADDR;
            PH_ADDR: nxt = ack ? PH_DATA : PH_WAIT;
            PH_WAIT: begin
                if (ack)          nxt = PH_DATA;
                else if (timeout) nxt = PH_IDLE;
            end
            PH_DATA: nxt = PH_IDLE;
            default: nxt = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            wcnt  <= '0;
            done  <= 1'b0;
            err   <= 1'b0;
        end else begin
            phase <= nxt;
            wcnt  <= (phase == PH_WAIT) ? wcnt + 1'b1 : '0;
            done  <= (phase == PH_DATA);
            err   <= reject | timeout;
        end
    end

endmodule

// File: rtl/ext_wr_cycle.sv
module ext_wr_cycle
    import ewc_pkg::*;
#(
    parameter int AW        = 24,
    parameter int TMO_WAITS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [AW-1:0]     req_addr,
    input  logic [1:0]        req_size,
    input  logic [2:0]        req_kind,
    input  logic [31:0]       req_data,
    input  logic              ack_ext,
    input  logic              ack_cs,
    output logic              busy,
    output logic [AW-1:0]     bus_addr,
    output logic [1:0]        bus_size,
    output logic [2:0]        bus_kind,
    output logic              cs_act,
    output logic              oe_act,
    output logic              rw,
    output logic [3:0]        be,
    output logic [31:0]       dout,
    output logic [1:0]        dout_oe,
    output logic              done,
    output logic              err
);

    phase_e            phase;
    wreq_t             held;
    logic [AW-1:0]     addr_q;
    logic              idle, ok, start, reject;
    logic [BYTES-1:0]  be_map;
    logic [LANES-1:0]  lane_use;
    logic [DATA_W-1:0] lane_data;

    assign idle   = (phase == PH_IDLE);
    assign ok     = size_ok(xfer_size_e'(req_size), req_addr[1:0]);
    assign start  = idle && req_valid && ok;
    assign reject = idle && req_valid && !ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            held   <= '0;
        end else if (start) begin
            addr_q    <= req_addr;
            held.size <= xfer_size_e'(req_size);
            held.kind <= req_kind;
            held.alo  <= req_addr[1:0];
            held.data <= req_data;
        end
    end

    ewc_seq #(.TMO_WAITS(TMO_WAITS)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .reject (reject),
        .ack    (ack_ext | ack_cs),
        .phase  (phase),
        .done   (done),
        .err    (err)
    );

    ewc_lane_map u_map (
        .req       (held),
        .be_map    (be_map),
        .lane_use  (lane_use),
        .lane_data (lane_data)
    );

    assign busy     = !idle;
    assign cs_act   = !idle;
    assign oe_act   = 1'b0;
    assign rw       = idle;
    assign bus_addr = addr_q;
    assign bus_size = held.size;
    assign bus_kind = held.kind;
    assign be       = (phase == PH_ADDR || phase == PH_WAIT) ? be_map : '0;
    assign dout_oe  = (phase == PH_WAIT || phase == PH_DATA) ? lane_use : '0;
    assign dout     = lane_data;

endmodule

// File: rtl/ext_wr_cycle_chk.sv
module ext_wr_cycle_chk #(
    parameter int AW = 24
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] bus_addr,
    input logic [1:0]    bus_size,
    input logic [2:0]    bus_kind,
    input logic          cs_act,
    input logic          oe_act,
    input logic          rw,
    input logic [3:0]    be,
    input logic [1:0]    dout_oe,
    input logic          done,
    input logic          err
);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !cs_act |-> (be == 4'b0) && (dout_oe == 2'b0) && rw);

    // R2
    addr_phase_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_act) |-> (dout_oe == 2'b0) && (be != 4'b0) && !rw && !oe_act);

    // R5
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cs_act && $past(cs_act)) |-> $stable(bus_addr) && $stable(bus_size) && $stable(bus_kind));

    // R7
    data_phase_len_chk: assert property (@(posedge clk) disable iff (rst)
        (cs_act && be == 4'b0) |=> !cs_act);

    // R8
    done_place_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !cs_act && $past(cs_act) && ($past(be) == 4'b0));

    // R6
    lane_in_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        (dout_oe != 2'b0) |-> cs_act);

    // R9
    pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({done, err}));

endmodule

bind ext_wr_cycle ext_wr_cycle_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_addr (bus_addr),
    .bus_size (bus_size),
    .bus_kind (bus_kind),
    .cs_act   (cs_act),
    .oe_act   (oe_act),
    .rw       (rw),
    .be       (be),
    .dout_oe  (dout_oe),
    .done     (done),
    .err      (err)
);

// File: tb/ext_wr_cycle_tb.sv
module ext_wr_cycle_tb;

    localparam int AW  = 24;
    localparam int TMO = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_size = 2'b00;
    logic [2:0]    req_kind = 3'b000;
    logic [31:0]   req_data = '0;
    logic          ack_ext = 1'b0;
    logic          ack_cs = 1'b0;
    logic          busy, cs_act, oe_act, rw, done, err;
    logic [AW-1:0] bus_addr;
    logic [1:0]    bus_size, dout_oe;
    logic [2:0]    bus_kind;
    logic [3:0]    be;
    logic [31:0]   dout;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    ext_wr_cycle #(.AW(AW), .TMO_WAITS(TMO)) u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_size(req_size), .req_kind(req_kind), .req_data(req_data),
        .ack_ext(ack_ext), .ack_cs(ack_cs), .busy(busy), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_kind(bus_kind), .cs_act(cs_act), .oe_act(oe_act),
        .rw(rw), .be(be), .dout(dout), .dout_oe(dout_oe), .done(done), .err(err)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_be(input logic [1:0] s, input logic [1:0] a);
        case (s)
            2'b01: return 4'b1000 >> a;
            2'b10: return (a == 2'd0) ? 4'b1100 : 4'b0011;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic logic [31:0] exp_data(input logic [1:0] s, input logic [31:0] d);
        case (s)
            2'b01: return {4{d[7:0]}};
            2'b10: return {2{d[15:0]}};
            default: return d;
        endcase
    endfunction

    function automatic logic [31:0] lane_mask(input logic [1:0] oe);
        return {{16{oe[1]}}, {16{oe[0]}}};
    endfunction

    task automatic check_idle(input string tag);
        chk(!cs_act && !oe_act && rw && be == 4'b0 && dout_oe == 2'b0 && !busy,
            tag, {cs_act, oe_act, rw, busy, be, dout_oe}, {4'b0010, 4'b0, 2'b0});
    endtask

    // One write; nwait wait phases, ack from cs when src==1; intr injects a request mid-cycle
    task automatic t_write(input logic [AW-1:0] a, input logic [1:0] s, input logic [2:0] k,
                           input logic [31:0] d, input int nwait, input bit src, input bit intr);
        logic [3:0]  eb;
        logic [1:0]  el;
        logic [31:0] ed;
        eb = exp_be(s, a[1:0]);
        el = {|eb[3:2], |eb[1:0]};
        ed = exp_data(s, d);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_size = s; req_kind = k; req_data = d;
        @(negedge clk);
        req_valid = 1'b0;
        // R2 address phase
        chk(cs_act && !oe_act && !rw && busy && bus_addr == a && bus_size == s && bus_kind == k,
            "R2 addr phase ctrl", {bus_addr, bus_size, bus_kind, cs_act, rw}, {a, s, k, 1'b1, 1'b0});
        chk(be == eb, "R3 byte enables", be, eb);
        chk(dout_oe == 2'b0, "R6 no data in addr phase", dout_oe, 2'b0);
        if (nwait == 0) begin
            if (src) ack_cs = 1'b1; else ack_ext = 1'b1;
        end
        for (int w = 1; w <= nwait; w++) begin
            @(negedge clk);
            ack_ext = 1'b0; ack_cs = 1'b0;
            chk(cs_act && be == eb && bus_addr == a && !rw, "R5 wait phase hold", {be, bus_addr}, {eb, a});
            chk(dout_oe == el && ((dout & lane_mask(el)) == (ed & lane_mask(el))),
                "R6 data on wait", {dout_oe, dout}, {el, ed});
            if (intr && w == 1) begin
                req_valid = 1'b1; req_addr = a ^ 24'h000100; req_size = 2'b00;
            end
            if (w == nwait) begin
                if (src) ack_cs = 1'b1; else ack_ext = 1'b1;
            end
        end
        @(negedge clk);
        ack_ext = 1'b0; ack_cs = 1'b0; req_valid = 1'b0;
        // R4 R7 data phase
        chk(cs_act && be == 4'b0 && !rw && bus_addr == a && bus_size == s && bus_kind == k,
            (nwait == 0) ? "R4 direct data phase" : "R7 data phase", {cs_act, be, bus_addr}, {1'b1, 4'b0, a});
        chk(dout_oe == el && ((dout & lane_mask(el)) == (ed & lane_mask(el))),
            "R6 data in data phase", {dout_oe, dout}, {el, ed});
        chk(!done, "R8 no early done", done, 1'b0);
        @(negedge clk);
        chk(done && !err, "R8 done pulse", {done, err}, 2'b10);
        check_idle("R8 idle after done");
        @(negedge clk);
        chk(!done, "R8 done one cycle", done, 1'b0);
        if (intr) chk(!cs_act, "R11 mid request ignored", cs_act, 1'b0);
    endtask

    task automatic t_reject(input logic [AW-1:0] a, input logic [1:0] s);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_size = s; req_data = 32'hDEAD_BEEF;
        @(negedge clk);
        req_valid = 1'b0;
        chk(err && !cs_act && !done, "R9 refused request", {err, cs_act, done}, 3'b100);
        @(negedge clk);
        chk(!err && !cs_act, "R9 err one cycle", {err, cs_act}, 2'b00);
    endtask

    task automatic t_timeout();
        @(negedge clk);
        req_valid = 1'b1; req_addr = 24'h00_4000; req_size = 2'b00; req_kind = 3'd2;
        @(negedge clk);
        req_valid = 1'b0;
        for (int w = 1; w <= TMO; w++) begin
            @(negedge clk);
            chk(cs_act && !err, "R10 still waiting", {cs_act, err}, 2'b10);
        end
        @(negedge clk);
        chk(err && !done && !cs_act, "R10 abort", {err, done, cs_act}, 3'b100);
        check_idle("R10 idle after abort");
        @(negedge clk);
        chk(!err && !done, "R10 no trailing pulse", {err, done}, 2'b00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_idle("R1 in reset");
        rst = 1'b0;
        @(negedge clk);
        check_idle("R1 after reset");
        chk(!done && !err, "R1 no pulses", {done, err}, 2'b00);

        t_write(24'h00_1000, 2'b00, 3'd1, 32'h1122_3344, 0, 1'b0, 1'b0);
        t_write(24'h00_1004, 2'b00, 3'd5, 32'hCAFE_F00D, 0, 1'b1, 1'b0);
        for (int o = 0; o < 4; o++)
            t_write(24'h00_2000 + o, 2'b01, 3'(o), 32'h0000_00A0 + o, o, o[0], 1'b0);
        t_write(24'h00_3000, 2'b10, 3'd6, 32'h0000_BEEF, 1, 1'b0, 1'b0);
        t_write(24'h00_3002, 2'b10, 3'd7, 32'h0000_5A5A, 2, 1'b1, 1'b0);
        t_write(24'h00_3008, 2'b00, 3'd3, 32'h8765_4321, 3, 1'b0, 1'b1);
        t_write(24'h00_300C, 2'b00, 3'd4, 32'h0F0F_F0F0, TMO, 1'b1, 1'b0);

        t_reject(24'h00_0001, 2'b10);
        t_reject(24'h00_0002, 2'b00);
        t_reject(24'h00_0000, 2'b11);
        t_timeout();

        t_write(24'h00_5003, 2'b01, 3'd2, 32'h0000_0077, 1, 1'b1, 1'b0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule